// File: doc/BRIEF.md
# Tree up/down route unit

This unit picks the output port of one switch in a 16-switch irregular on-chip network. Routing follows a spanning tree built breadth-first from one root switch. Links of the tree that lead toward the root, together with every extra wired or radio shortcut, are treated as "up" links. Tree links that lead away from the root are "down" links. A packet may climb any number of up links and then descend any number of down links, and it may never climb again after it has descended. The unit is purely combinational. It receives the address of the switch it sits in, the destination address and a phase bit telling whether the packet has already descended. It returns a one-hot port choice, the new phase bit and an error flag.

Each switch address has five 3-bit digits. Digit i sits at bits [3i+2:3i], and digit 0 is the level nearest the root. The root address is all zeros. A switch at depth L carries the digits of its parent, plus digit L-1 set to k when it is the k-th child of that parent. Children are counted from 1 in ascending switch number. All digits at or beyond the switch's own depth are zero. The parent list, the shortcut end pairs and the root are elaboration parameters, and the address of every switch is derived from them. The shortcut kind (wired or radio) plays no part in the decision.

Top module: `updn_route`

## Requirements
- R1: When the destination equals the current address and the current address belongs to a switch, only port 0 (local ejection) is selected and out_down equals in_down.
- R2: When the destination lies strictly below the current switch in the tree, the unit selects port 1+d and sets out_down to 1, whatever the value of in_down. Here d is the destination digit at the current switch's depth, and d=1 maps to port 2 and d=4 to port 5.
- R3: When the destination is outside the current subtree and in_down is 0, the unit may select a shortcut j that ends at this switch. It does so when the far end of that shortcut is the destination or an ancestor of the destination, and then it selects port 6+j with out_down 0.
- R4: When several shortcuts qualify, the one whose far end is deepest in the tree wins. Among shortcuts whose far ends share that depth, the lowest index wins.
- R5: When the destination is outside the current subtree, in_down is 0 and no shortcut qualifies, the unit selects port 1 (the parent tree link) with out_down 0.
- R6: When in_down is 1 and the destination is outside the current subtree, route_err is 1, no port is selected and out_down equals in_down.
- R7: A current address that matches no switch raises route_err with no port selected, even when it equals the destination.
- R8: At most one port is selected at a time, and exactly one is selected whenever route_err is 0.
- R9: If each hop follows the unit's choice, every source reaches every destination within 11 hops, and no up hop (port 1 or a shortcut) follows a down hop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| here_addr | input | 15 | Tree address of the switch making the decision |
| dst_addr | input | 15 | Tree address of the packet's destination |
| in_down | input | 1 | 1 once the packet has taken a down hop |
| out_sel | output | 12 | One-hot port: 0 local, 1 parent, 2..5 children 1..4, 6..11 shortcuts 0..5 |
| out_down | output | 1 | Phase bit to carry with the packet to the next switch |
| route_err | output | 1 | Route is illegal or current address unknown; no port selected |

## Verification
Every source/destination pair is walked hop by hop through the unit's own choices. A design that climbed after descending, or that sent a packet to a port with no link behind it, breaks the walk at once. Directed cases target a switch with two qualifying shortcuts with far ends at different depths: a design that took the first hit instead of the deepest would pick port 6 instead of port 10. The directed cases also cover an unknown address that equals the destination, where a design that checked for arrival before checking membership would eject instead of flagging an error. A down-phase packet whose destination is outside the subtree must raise the error rather than fall back to the parent link. A down-phase packet whose destination lies below the switch must still descend.

// File: rtl/updn_pkg.sv
package updn_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DIGITS    = 5;                       // tree depth the address can hold
  localparam int MAX_CHILD = 4;                       // children per switch
  localparam int DIG_W     = $clog2(MAX_CHILD + 1);   // digit holds 0 (none) .. MAX_CHILD
  localparam int AW        = DIGITS * DIG_W;
  localparam int LVW       = $clog2(DIGITS + 1);

  typedef logic [AW-1:0] addr_t;

  // depth of an address: index of its first zero digit
  function automatic int level_of(addr_t a);
    int lv;
    lv = DIGITS;
    for (int i = DIGITS - 1; i >= 0; i--) begin
      if (a[i*DIG_W +: DIG_W] == '0) lv = i;
    end
    return lv;
  endfunction

  // ones over the digits shallower than depth d
  function automatic addr_t low_mask(int d);
    addr_t m;
    m = '0;
    for (int k = 0; k < AW; k++) begin
      if (k < d * DIG_W) m[k] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/updn_sc_probe.sv
module updn_sc_probe
  import updn_pkg::*;
#(
  parameter addr_t A_ADDR = '0,
  parameter addr_t B_ADDR = '0
) (
  input  addr_t          here_addr,
  input  addr_t          dst_addr,
  output logic           hit,
  output logic [LVW-1:0] far_lvl
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int    LA = level_of(A_ADDR);
  localparam int    LB = level_of(B_ADDR);
  localparam addr_t MA = low_mask(LA);
  localparam addr_t MB = low_mask(LB);

  logic at_a, at_b, cov_a, cov_b;

  assign at_a  = (here_addr == A_ADDR);
  assign at_b  = (here_addr == B_ADDR);
  // far end is the destination or one of its ancestors
  assign cov_a = ((dst_addr & MA) == A_ADDR);
  assign cov_b = ((dst_addr & MB) == B_ADDR);

  assign hit     = (at_a && cov_b) || (at_b && cov_a);
  assign far_lvl = at_a ? LVW'(LB) : LVW'(LA);
endmodule

// File: rtl/updn_sc_pick.sv
module updn_sc_pick
  import updn_pkg::*;
#(
  parameter int NSC = 6
) (
  input  logic [NSC-1:0]     hit,
  input  logic [NSC*LVW-1:0] lvl,
  output logic [NSC-1:0]     grant
);
  timeunit 1ns;
  timeprecision 1ps;

  // deepest far end wins; strict compare keeps the lower index on a tie
  always_comb begin
    logic           have;
    logic [LVW-1:0] best;
    grant = '0;
    have  = 1'b0;
    best  = '0;
    for (int j = 0; j < NSC; j++) begin
      if (hit[j] && (!have || lvl[j*LVW +: LVW] > best)) begin
        grant    = '0;
        grant[j] = 1'b1;
        have     = 1'b1;
        best     = lvl[j*LVW +: LVW];
      end
    end
  end
endmodule

// File: rtl/updn_tree_step.sv
module updn_tree_step
  import updn_pkg::*;
(
  input  addr_t                here_addr,
  input  addr_t                dst_addr,
  output logic                 is_self,
  output logic                 in_sub,
  output logic [MAX_CHILD-1:0] child_oh
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [DIG_W-1:0] branch;

  always_comb begin
    logic found;
    found  = 1'b0;
    in_sub = 1'b0;
    branch = '0;
    for (int i = 0; i < DIGITS; i++) begin
      if (!found && here_addr[i*DIG_W +: DIG_W] == '0) begin
        found  = 1'b1;
        branch = dst_addr[i*DIG_W +: DIG_W];
        in_sub = ((dst_addr & low_mask(i)) == here_addr) && (branch != '0);
      end
    end
  end

  assign is_self = (here_addr == dst_addr);

  for (genvar k = 0; k < MAX_CHILD; k++) begin : g_child
    assign child_oh[k] = in_sub && (branch == DIG_W'(k + 1));
  end
endmodule

// File: rtl/updn_locate.sv
module updn_locate
  import updn_pkg::*;
#(
  parameter int                    N_NODES  = 16,
  parameter logic [N_NODES*AW-1:0] NODE_TAB = '0
) (
  input  addr_t here_addr,
  output logic  known
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [N_NODES-1:0] match;

  for (genvar n = 0; n < N_NODES; n++) begin : g_node
    assign match[n] = (here_addr == NODE_TAB[n*AW +: AW]);
  end

  assign known = |match;
endmodule

// File: rtl/updn_route.sv
module updn_route
  import updn_pkg::*;
#(
  parameter int N_NODES = 16,
  parameter int ROOT    = 5,
  parameter int NSC     = 6,
  // parent of switch n at [4n+3:4n]; the root's own entry is ignored
  parameter logic [N_NODES*$clog2(N_NODES)-1:0] PARENT =
    {4'd13, 4'd11, 4'd9, 4'd7, 4'd7, 4'd4, 4'd3, 4'd2,
     4'd1,  4'd8,  4'd5, 4'd0, 4'd0, 4'd5, 4'd5, 4'd5},
  // shortcut j joins SC_END_A[j] and SC_END_B[j]
  parameter logic [NSC*$clog2(N_NODES)-1:0] SC_END_A =
    {4'd1, 4'd10, 4'd14, 4'd15, 4'd12, 4'd11},
  parameter logic [NSC*$clog2(N_NODES)-1:0] SC_END_B =
    {4'd3, 4'd14, 4'd4, 4'd2, 4'd8, 4'd10},
  localparam int NPORT = 2 + MAX_CHILD + NSC
) (
  input  logic [AW-1:0]    here_addr,
  input  logic [AW-1:0]    dst_addr,
  input  logic             in_down,
  output logic [NPORT-1:0] out_sel,
  output logic             out_down,
  output logic             route_err
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NID_W       = $clog2(N_NODES);
  localparam int PORT_LOCAL  = 0;
  localparam int PORT_PARENT = 1;
  localparam int CHILD_BASE  = 2;
  localparam int SC_BASE     = CHILD_BASE + MAX_CHILD;

  function automatic int parent_of(int n);
    return int'(PARENT[n*NID_W +: NID_W]);
  endfunction

  // 1-based rank of n among its siblings, by switch number
  function automatic int ordinal(int n);
    int r;
    r = 1;
    for (int m = 0; m < N_NODES; m++) begin
      if (m < n && m != ROOT && parent_of(m) == parent_of(n)) r++;
    end
    return r;
  endfunction

  function automatic logic [N_NODES*AW-1:0] build_tab();
    logic [N_NODES*AW-1:0] t;
    logic [N_NODES-1:0]    done;
    addr_t                 a;
    int                    p, lv;
    t    = '0;
    done = '0;
    done[ROOT] = 1'b1;
    for (int pass = 0; pass < DIGITS; pass++) begin
      for (int n = 0; n < N_NODES; n++) begin
        p = parent_of(n);
        if (!done[n] && done[p]) begin
          a  = t[p*AW +: AW];
          lv = level_of(a);
          if (lv < DIGITS) a[lv*DIG_W +: DIG_W] = DIG_W'(ordinal(n));
          t[n*AW +: AW] = a;
          done[n]       = 1'b1;
        end
      end
    end
    return t;
  endfunction

  localparam logic [N_NODES*AW-1:0] NODE_TAB = build_tab();

  logic                 here_known;
  logic                 is_self;
  logic                 in_sub;
  logic [MAX_CHILD-1:0] child_oh;
  logic [NSC-1:0]       sc_hit;
  logic [NSC*LVW-1:0]   sc_lvl;
  logic [NSC-1:0]       sc_grant;

  updn_locate #(
    .N_NODES (N_NODES),
    .NODE_TAB(NODE_TAB)
  ) u_locate (
    .here_addr(here_addr),
    .known    (here_known)
  );

  updn_tree_step u_step (
    .here_addr(here_addr),
    .dst_addr (dst_addr),
    .is_self  (is_self),
    .in_sub   (in_sub),
    .child_oh (child_oh)
  );

  for (genvar j = 0; j < NSC; j++) begin : g_sc
    localparam int EA = int'(SC_END_A[j*NID_W +: NID_W]);
    localparam int EB = int'(SC_END_B[j*NID_W +: NID_W]);
    updn_sc_probe #(
      .A_ADDR(NODE_TAB[EA*AW +: AW]),
      .B_ADDR(NODE_TAB[EB*AW +: AW])
    ) u_probe (
      .here_addr(here_addr),
      .dst_addr (dst_addr),
      .hit      (sc_hit[j]),
      .far_lvl  (sc_lvl[j*LVW +: LVW])
    );
  end

  updn_sc_pick #(
    .NSC(NSC)
  ) u_pick (
    .hit  (sc_hit),
    .lvl  (sc_lvl),
    .grant(sc_grant)
  );

  always_comb begin
    out_sel   = '0;
    out_down  = in_down;
    route_err = 1'b0;
    if (!here_known) begin
      route_err = 1'b1;
    end else if (is_self) begin
      out_sel[PORT_LOCAL] = 1'b1;
    end else if (in_sub) begin
      if (child_oh == '0) begin
        route_err = 1'b1;
      end else begin
        out_sel[CHILD_BASE +: MAX_CHILD] = child_oh;
        out_down = 1'b1;
      end
    end else if (in_down) begin
      route_err = 1'b1;
    end else if (sc_grant != '0) begin
      out_sel[SC_BASE +: NSC] = sc_grant;
      out_down = 1'b0;
    end else begin
      out_sel[PORT_PARENT] = 1'b1;
      out_down = 1'b0;
    end
  end
endmodule

// File: rtl/updn_route_chk.sv
module updn_route_chk
  import updn_pkg::*;
#(
  parameter int NSC   = 6,
  parameter int NPORT = 2 + MAX_CHILD + NSC
) (
  input logic [AW-1:0]    here_addr,
  input logic [AW-1:0]    dst_addr,
  input logic             in_down,
  input logic [NPORT-1:0] out_sel,
  input logic             out_down,
  input logic             route_err
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int SC_BASE = 2 + MAX_CHILD;

  logic up_pick, down_pick;
  assign up_pick   = out_sel[1] || (out_sel[SC_BASE +: NSC] != '0);
  assign down_pick = (out_sel[2 +: MAX_CHILD] != '0);

  always_comb begin
    if (!$isunknown({here_addr, dst_addr, in_down, out_sel, out_down, route_err})) begin
      assert_sel_onehot_R8: assert ($onehot0(out_sel) && (route_err || $countones(out_sel) == 1))
        else $error("port choice not one-hot");
      assert_err_no_port_R6: assert (!route_err || out_sel == '0)
        else $error("port selected together with error");
      assert_self_local_R1: assert (!(here_addr == dst_addr && !route_err) ||
                                    (out_sel[0] && out_down == in_down))
        else $error("arrival did not eject locally");
      assert_no_climb_after_down_R9: assert (!(in_down && !route_err) || !up_pick)
        else $error("up hop after down hop");
      assert_down_marks_phase_R2: assert (!down_pick || out_down)
        else $error("down hop without phase set");
      assert_up_keeps_phase_R5: assert (!up_pick || !out_down)
        else $error("up hop with phase set");
    end
  end
endmodule

bind updn_route updn_route_chk #(
  .NSC  (NSC),
  .NPORT(NPORT)
) u_chk (
  .here_addr(here_addr),
  .dst_addr (dst_addr),
  .in_down  (in_down),
  .out_sel  (out_sel),
  .out_down (out_down),
  .route_err(route_err)
);

// File: tb/updn_route_bench.sv
module updn_route_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NN      = 16;
  localparam int DG      = 5;
  localparam int DW      = 3;
  localparam int AW      = DG * DW;
  localparam int MAXCH   = 4;
  localparam int NSC     = 6;
  localparam int NP      = 2 + MAXCH + NSC;
  localparam int ROOT    = 5;
  localparam int HOP_MAX = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] here_addr = '0;
  logic [AW-1:0] dst_addr = '0;
  logic          in_down = 1'b0;
  logic [NP-1:0] out_sel;
  logic          out_down;
  logic          route_err;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  int            par [NN];
  int            sca [NSC];
  int            scb [NSC];
  logic [AW-1:0] addr[NN];

  always #2 clk = ~clk;

  updn_route u_updn_route (
    .here_addr(here_addr),
    .dst_addr (dst_addr),
    .in_down  (in_down),
    .out_sel  (out_sel),
    .out_down (out_down),
    .route_err(route_err)
  );

  function automatic int digit(logic [AW-1:0] a, int i);
    return int'(a[i*DW +: DW]);
  endfunction

  function automatic int lvl(logic [AW-1:0] a);
    for (int i = 0; i < DG; i++) if (digit(a, i) == 0) return i;
    return DG;
  endfunction

  function automatic int idx_of(logic [AW-1:0] a);
    for (int n = 0; n < NN; n++) if (addr[n] == a) return n;
    return -1;
  endfunction

  // d equals t or lies below it
  function automatic bit covers(logic [AW-1:0] t, logic [AW-1:0] d);
    for (int i = 0; i < lvl(t); i++) if (digit(t, i) != digit(d, i)) return 0;
    return 1;
  endfunction

  function automatic int ordinal(int n);
    int r;
    r = 1;
    for (int m = 0; m < n; m++) if (m != ROOT && par[m] == par[n]) r++;
    return r;
  endfunction

  function automatic int neighbor(int cur, int p);
    if (p == 1) return (cur == ROOT) ? -1 : par[cur];
    if (p >= 2 && p < 2 + MAXCH) begin
      for (int n = 0; n < NN; n++)
        if (n != ROOT && par[n] == cur && ordinal(n) == p - 1) return n;
      return -1;
    end
    if (p >= 2 + MAXCH && p < NP) begin
      if (sca[p-2-MAXCH] == cur) return scb[p-2-MAXCH];
      if (scb[p-2-MAXCH] == cur) return sca[p-2-MAXCH];
    end
    return -1;
  endfunction

  function automatic int port_of(logic [NP-1:0] s);
    for (int p = 0; p < NP; p++) if (s[p]) return p;
    return -1;
  endfunction

  // behavioural expectation from the requirements
  task automatic model(input logic [AW-1:0] h, input logic [AW-1:0] d, input logic din,
                       output logic [NP-1:0] s, output logic dn, output logic er);
    int hi, k, best, bl, far;
    s = '0; dn = din; er = 1'b0;
    hi = idx_of(h);
    if (hi < 0) er = 1'b1;
    else if (d == h) s[0] = 1'b1;
    else if (covers(h, d)) begin
      k = digit(d, lvl(h));
      if (k < 1 || k > MAXCH) er = 1'b1;
      else begin s[1+k] = 1'b1; dn = 1'b1; end
    end else if (din) er = 1'b1;
    else begin
      best = -1; bl = -1;
      for (int j = 0; j < NSC; j++) begin
        far = -1;
        if (sca[j] == hi) far = scb[j];
        else if (scb[j] == hi) far = sca[j];
        if (far >= 0 && covers(addr[far], d) && lvl(addr[far]) > bl) begin
          best = j; bl = lvl(addr[far]);
        end
      end
      if (best >= 0) s[2+MAXCH+best] = 1'b1;
      else s[1] = 1'b1;
      dn = 1'b0;
    end
  endtask

  function automatic string tag_for(logic [NP-1:0] s, logic er, logic [AW-1:0] h);
    if (er) return (idx_of(h) < 0) ? "R7" : "R6";
    if (s[0]) return "R1";
    if (s[1]) return "R5";
    if (s[2 +: MAXCH] != '0) return "R2";
    return "R3";
  endfunction

  task automatic note(input bit ok, input string msg);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic apply(input logic [AW-1:0] h, input logic [AW-1:0] d, input logic din,
                       input string tag);
    logic [NP-1:0] es;
    logic          ed, ee;
    string         t;
    @(posedge clk);
    here_addr = h; dst_addr = d; in_down = din;
    @(negedge clk);
    model(h, d, din, es, ed, ee);
    t = (tag == "") ? tag_for(es, ee, h) : tag;
    note(out_sel === es && out_down === ed && route_err === ee,
         $sformatf("%s: sel=%b down=%b err=%b expected sel=%b down=%b err=%b",
                   t, out_sel, out_down, route_err, es, ed, ee));
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL R9: watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int cur, nxt, p;
    bit dn, arrived, stop;
    logic [AW-1:0] a;
    bit done[NN];

    par = '{5, 5, 5, 0, 0, 5, 8, 1, 2, 3, 4, 7, 7, 9, 11, 13};
    sca = '{11, 12, 15, 14, 10, 1};
    scb = '{10, 8, 2, 4, 14, 3};
    for (int n = 0; n < NN; n++) begin addr[n] = '0; done[n] = 0; end
    done[ROOT] = 1;
    for (int pass = 0; pass <= DG; pass++) begin
      for (int n = 0; n < NN; n++) begin
        if (!done[n] && done[par[n]]) begin
          a = addr[par[n]];
          a[lvl(a)*DW +: DW] = DW'(ordinal(n));
          addr[n] = a;
          done[n] = 1;
        end
      end
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: root to root with phase up ejects locally (R1)
    note(out_sel === NP'(1) && out_down === 1'b0 && route_err === 1'b0,
         $sformatf("R1 reset: sel=%b down=%b err=%b expected sel=%b down=0 err=0",
                   out_sel, out_down, route_err, NP'(1)));
    rst_n = 1'b1;

    // R4: switch 10 has shortcuts to 11 (depth 3) and 14 (depth 4); 14 must win
    apply(addr[10], addr[14], 1'b0, "R4");
    note(out_sel[10] === 1'b1, $sformatf("R4: sel=%b expected port 10", out_sel));
    // R3: shortcut 5 from 3 reaches the branch holding 14
    apply(addr[3], addr[14], 1'b0, "R3");
    // R5: deepest leaf climbs its parent link
    apply(addr[15], addr[14], 1'b0, "R5");
    // R6: same pair in down phase is illegal
    apply(addr[15], addr[14], 1'b1, "R6");
    note(route_err === 1'b1 && out_sel === '0,
         $sformatf("R6: err=%b sel=%b expected err=1 sel=0", route_err, out_sel));
    // R2: down phase still descends into own subtree
    apply(addr[0], addr[10], 1'b1, "R2");
    // R1: arrival keeps the phase bit
    apply(addr[7], addr[7], 1'b1, "R1");
    // R7: unknown address, also when it equals the destination
    apply(AW'(7), addr[3], 1'b0, "R7");
    apply(AW'(7), AW'(7), 1'b0, "R7");
    note(route_err === 1'b1, $sformatf("R7: err=%b expected 1", route_err));

    // R9/R8: hop-by-hop walk over every pair, following the unit's own choice
    for (int s = 0; s < NN; s++) begin
      for (int d = 0; d < NN; d++) begin
        cur = s; dn = 0; arrived = 0; stop = 0;
        for (int hop = 0; hop <= HOP_MAX; hop++) begin
          if (!arrived && !stop) begin
            apply(addr[cur], addr[d], dn, "");
            if (route_err || $countones(out_sel) != 1) begin
              stop = 1;
              note(0, $sformatf("R8: %0d->%0d at %0d sel=%b err=%b expected one port",
                                s, d, cur, out_sel, route_err));
            end else begin
              p = port_of(out_sel);
              if (p == 0) begin
                arrived = (cur == d);
                if (cur != d) stop = 1;
              end else begin
                nxt = neighbor(cur, p);
                if (dn && !(p >= 2 && p < 2 + MAXCH)) begin
                  stop = 1;
                  note(0, $sformatf("R9: %0d->%0d up port %0d at %0d after down expected down",
                                    s, d, p, cur));
                end else if (nxt < 0) begin
                  stop = 1;
                  note(0, $sformatf("R9: %0d->%0d port %0d at %0d has no link expected a link",
                                    s, d, p, cur));
                end else begin
                  if (p >= 2 && p < 2 + MAXCH) dn = 1;
                  cur = nxt;
                end
              end
            end
          end
        end
        note(arrived, $sformatf("R9: %0d->%0d arrived=%0d expected 1 (stopped at %0d)",
                                s, d, arrived, cur));
      end
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule